// File: doc/BRIEF.md
# Single-Precision Float Min/Max Unit

This is a purely combinational unit that takes two 32-bit IEEE-754 single-precision operands and returns either their minimum or their maximum. The result is exact and follows the minimumNumber/maximumNumber NaN convention. The operation is picked by decoding a 7-bit function field and a 3-bit rounding-mode field from the instruction word. There is no floating-point arithmetic core. Ordering is worked out straight from the sign, exponent and fraction bit patterns.

Alongside the result, the unit drives an invalid-operation flag that is meant to be ORed into the floating-point status register. It also drives an illegal-encoding indication so the surrounding pipeline can raise an exception. Operand storage, the status register and the other floating-point operations are left to the surrounding datapath.

Top module: `fmm_unit`

## Requirements
- R1: An encoding is legal only when the function field is 7'b0010100 and the mode field is 3'b000 (minimum) or 3'b001 (maximum). Any other encoding drives illegal_o high, res_o to 0 and invalid_o low.
- R2: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. An infinity (fraction zero) is ordered as a number.
- R3: A NaN whose bit 22 is clear is signaling. If either operand is a signaling NaN on a legal encoding, invalid_o is high. This holds even when the result is a number.
- R4: invalid_o stays low when no signaling NaN is present, including when one or both operands are quiet NaNs.
- R5: When exactly one operand is a NaN, res_o equals the other operand bit for bit.
- R6: When both operands are NaN, res_o is the canonical quiet NaN 32'h7FC00000.
- R7: When the sign bits (bit 31) differ and neither operand is NaN, minimum returns the operand with the sign set and maximum returns the one with the sign clear. So min(-0,+0) = 32'h80000000 and max(-0,+0) = 32'h00000000.
- R8: When the signs are equal and neither operand is NaN, the numerically smaller (minimum) or larger (maximum) operand is returned. When the two are equal, op_b_i is returned.
- R9: The ordering in R8 is correct for infinities and for subnormals, including mixes of subnormal, normal and infinite operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct7_i | input | 7 | Function field of the instruction |
| rm_i | input | 3 | Mode field: 000 minimum, 001 maximum |
| op_a_i | input | 32 | First operand, single precision |
| op_b_i | input | 32 | Second operand, single precision |
| res_o | output | 32 | Selected result |
| invalid_o | output | 1 | Invalid-operation flag |
| illegal_o | output | 1 | Encoding is not a min/max operation |

## Verification
The unit holds no state, so a wrong classification or a wrong ordering decision shows up at res_o or invalid_o in the same cycle the operands are applied. No history is needed to expose it. A NaN misread as a number, or the reverse, shows up as a result that is not the expected operand or the canonical NaN. A swapped sign rule shows up on the signed-zero pairs. An inverted magnitude rule shows up on any same-sign negative pair. Every such fault is therefore visible on the first vector that exercises it.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned FP_W  = 1 + EXP_W + MAN_W;

  localparam logic [6:0] F7_MINMAX = 7'b0010100;
  localparam logic [2:0] RM_MIN    = 3'b000;
  localparam logic [2:0] RM_MAX    = 3'b001;

  typedef enum logic {
    SEL_MIN = 1'b0,
    SEL_MAX = 1'b1
  } sel_e;
endpackage

// File: rtl/fmm_decode.sv
module fmm_decode
  import fmm_pkg::*;
(
  input  logic [6:0] funct7_i,
  input  logic [2:0] rm_i,
  output logic       legal_o,
  output sel_e       sel_o
);
  logic f7_hit;

  always_comb begin
    f7_hit  = (funct7_i == F7_MINMAX);
    legal_o = 1'b0;
    sel_o   = SEL_MIN;
    if (f7_hit) begin
      unique case (rm_i)
        RM_MIN: begin legal_o = 1'b1; sel_o = SEL_MIN; end
        RM_MAX: begin legal_o = 1'b1; sel_o = SEL_MAX; end
        default: legal_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int unsigned EXP_W = fmm_pkg::EXP_W,
  parameter int unsigned MAN_W = fmm_pkg::MAN_W,
  localparam int unsigned FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0] op_i,
  output logic            sign_o,
  output logic [FP_W-2:0] mag_o,
  output logic            is_nan_o,
  output logic            is_snan_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;

  always_comb begin
    sign_o    = op_i[FP_W-1];
    mag_o     = op_i[FP_W-2:0];
    exp_f     = op_i[FP_W-2 -: EXP_W];
    man_f     = op_i[MAN_W-1:0];
    exp_max   = &exp_f;
    is_nan_o  = exp_max && (|man_f);
    // quiet bit is the fraction MSB
    is_snan_o = is_nan_o && !man_f[MAN_W-1];
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
#(
  parameter int unsigned MAG_W = fmm_pkg::FP_W - 1
) (
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  input  sel_e             sel_i,
  output logic             pick_a_o
);
  logic a_mag_lt;
  logic a_mag_gt;
  logic a_less;
  logic a_more;

  always_comb begin
    a_mag_lt = (mag_a_i < mag_b_i);
    a_mag_gt = (mag_a_i > mag_b_i);
    if (sign_a_i != sign_b_i) begin
      a_less = sign_a_i;
      a_more = sign_b_i;
    end else if (!sign_a_i) begin
      a_less = a_mag_lt;
      a_more = a_mag_gt;
    end else begin
      // negative pair: larger magnitude is the smaller value
      a_less = a_mag_gt;
      a_more = a_mag_lt;
    end
    // strict compare: ties fall to operand b
    pick_a_o = (sel_i == SEL_MIN) ? a_less : a_more;
  end

  always_comb begin
    if (sign_a_i && !sign_b_i && sel_i == SEL_MAX)
      AST_MAX_TAKES_POS: assert (!pick_a_o) else $error("max chose negative"); // R7
    if (sign_a_i == sign_b_i && mag_a_i == mag_b_i)
      AST_TIE_TAKES_B: assert (!pick_a_o) else $error("tie chose a"); // R8
  end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
(
  input  logic [6:0]      funct7_i,
  input  logic [2:0]      rm_i,
  input  logic [FP_W-1:0] op_a_i,
  input  logic [FP_W-1:0] op_b_i,
  output logic [FP_W-1:0] res_o,
  output logic            invalid_o,
  output logic            illegal_o
);
  localparam logic [FP_W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam int unsigned N_OPS = 2;

  logic            legal;
  sel_e            sel;
  logic [FP_W-1:0] ops     [N_OPS];
  logic            sgn     [N_OPS];
  logic [FP_W-2:0] mag     [N_OPS];
  logic            nan_q   [N_OPS];
  logic            snan_q  [N_OPS];
  logic            pick_a;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  fmm_decode u_dec (
    .funct7_i (funct7_i),
    .rm_i     (rm_i),
    .legal_o  (legal),
    .sel_o    (sel)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i      (ops[g]),
      .sign_o    (sgn[g]),
      .mag_o     (mag[g]),
      .is_nan_o  (nan_q[g]),
      .is_snan_o (snan_q[g])
    );
  end

  fmm_order #(.MAG_W(FP_W-1)) u_ord (
    .sign_a_i (sgn[0]),
    .sign_b_i (sgn[1]),
    .mag_a_i  (mag[0]),
    .mag_b_i  (mag[1]),
    .sel_i    (sel),
    .pick_a_o (pick_a)
  );

  always_comb begin
    illegal_o = !legal;
    invalid_o = legal && (snan_q[0] || snan_q[1]);
    res_o     = '0;
    if (legal) begin
      if (nan_q[0] && nan_q[1])      res_o = CANON_NAN;
      else if (nan_q[0])             res_o = op_b_i;
      else if (nan_q[1])             res_o = op_a_i;
      else                           res_o = pick_a ? op_a_i : op_b_i;
    end
  end

  // port-level checks, recomputed from raw fields
  logic a_nan_p, b_nan_p, a_snan_p, b_snan_p;
  always_comb begin
    a_nan_p  = (op_a_i[30:23] == 8'hFF) && (op_a_i[22:0] != 0);
    b_nan_p  = (op_b_i[30:23] == 8'hFF) && (op_b_i[22:0] != 0);
    a_snan_p = a_nan_p && !op_a_i[22];
    b_snan_p = b_nan_p && !op_b_i[22];
    if (illegal_o)
      AST_ILLEGAL_QUIET: assert (res_o == '0 && !invalid_o) else $error("illegal not quiet"); // R1
    if (invalid_o)
      AST_INV_NEEDS_SNAN: assert (a_snan_p || b_snan_p) else $error("invalid w/o snan"); // R3
    if (!illegal_o && (a_nan_p ^ b_nan_p))
      AST_NAN_PASSES_OTHER: assert (res_o == (a_nan_p ? op_b_i : op_a_i)) else $error("nan pass"); // R5
    if (!illegal_o && a_nan_p && b_nan_p)
      AST_TWO_NAN_CANON: assert (res_o == 32'h7FC00000) else $error("not canonical"); // R6
    if (!illegal_o && !a_nan_p && !b_nan_p)
      AST_RES_IS_OPERAND: assert (res_o == op_a_i || res_o == op_b_i) else $error("foreign result"); // R8
  end
endmodule

// File: tb/fmm_unit_tb_top.sv
module fmm_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [6:0]  funct7;
  logic [2:0]  rm;
  logic [31:0] op_a, op_b, res;
  logic        invalid, illegal;

  fmm_unit dut_i (
    .funct7_i (funct7), .rm_i (rm), .op_a_i (op_a), .op_b_i (op_b),
    .res_o (res), .invalid_o (invalid), .illegal_o (illegal)
  );

  typedef struct {
    logic [31:0] e_res;
    logic        e_inv;
    logic        e_ill;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic bit f_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // total-order key: unsigned compare matches numeric order for non-NaN
  function automatic logic [31:0] key(logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  task automatic drive(input logic [6:0] f7, input logic [2:0] m,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    item_t it;
    bit legal, an, bn;
    @(posedge clk); #2;
    funct7 = f7; rm = m; op_a = a; op_b = b;
    legal = (f7 == 7'b0010100) && (m == 3'b000 || m == 3'b001);
    an = f_nan(a); bn = f_nan(b);
    it.tag   = tag;
    it.e_ill = !legal;
    it.e_inv = legal && ((an && !a[22]) || (bn && !b[22]));
    if (!legal)          it.e_res = 32'h0;
    else if (an && bn)   it.e_res = 32'h7FC0_0000;
    else if (an)         it.e_res = b;
    else if (bn)         it.e_res = a;
    else if (m == 3'b000) it.e_res = (key(a) < key(b)) ? a : b;
    else                 it.e_res = (key(a) > key(b)) ? a : b;
    sb_q.push_back(it);
  endtask

  task automatic mn(input logic [31:0] a, input logic [31:0] b, input string tag);
    drive(7'b0010100, 3'b000, a, b, tag);
  endtask
  task automatic mx(input logic [31:0] a, input logic [31:0] b, input string tag);
    drive(7'b0010100, 3'b001, a, b, tag);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (res !== it.e_res || invalid !== it.e_inv || illegal !== it.e_ill) begin
        fails++;
        $display("FAIL %s: res=%h inv=%b ill=%b expected res=%h inv=%b ill=%b",
                 it.tag, res, invalid, illegal, it.e_res, it.e_inv, it.e_ill);
      end
    end
  end

  function automatic logic [31:0] rnd_norm();
    logic [31:0] r;
    logic [7:0]  e;
    r = $urandom();
    e = 8'($urandom_range(254, 1));
    return {r[31], e, r[22:0]};
  endfunction

  initial begin
    funct7 = '0; rm = '0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: idle encoding is illegal and quiet
    drive(7'b0000000, 3'b000, 32'h0, 32'h0, "R1 reset idle");
    drive(7'b0010100, 3'b010, 32'h3F80_0000, 32'h4000_0000, "R1 rm=010");
    drive(7'b0010100, 3'b111, 32'h7F80_0001, 32'h0, "R1 rm=111 snan");
    drive(7'b0010000, 3'b000, 32'h3F80_0000, 32'h4000_0000, "R1 bad funct7");
    mn(32'h3F80_0000, 32'h4000_0000, "R1 min legal");
    mx(32'h3F80_0000, 32'h4000_0000, "R1 max legal");
    // R2 infinity is a number
    mn(32'h7F80_0000, 32'h3F80_0000, "R2 min +inf");
    mx(32'hFF80_0000, 32'h3F80_0000, "R2 max -inf");
    mx(32'h7F80_0000, 32'h7FC0_0000, "R2 inf vs qnan");
    // R3 snan raises invalid even with numeric result
    mn(32'h7F80_0001, 32'h4040_0000, "R3 snan a");
    mx(32'h3F80_0000, 32'hFFA0_0000, "R3 snan b");
    mn(32'h7FA0_0000, 32'h7FC0_0000, "R3 snan+qnan");
    mx(32'h7F80_0001, 32'hFF80_0002, "R3 two snan");
    // R4 quiet nan alone no flag
    mn(32'h7FC0_0000, 32'h3F80_0000, "R4 qnan a");
    mx(32'hFFC1_2345, 32'h7FFF_FFFF, "R4 two qnan");
    // R5 one nan passes other unchanged
    mn(32'h0000_0001, 32'h7FC0_0001, "R5 sub vs qnan");
    mx(32'h7FFF_0000, 32'h8000_0000, "R5 qnan vs -0");
    // R6 canonical nan
    mn(32'hFFFF_FFFF, 32'h7F80_0001, "R6 both nan min");
    mx(32'h7FC0_0000, 32'h7FC0_0000, "R6 both nan max");
    // R7 sign rule and zeros
    mn(32'h8000_0000, 32'h0000_0000, "R7 min -0,+0");
    mn(32'h0000_0000, 32'h8000_0000, "R7 min +0,-0");
    mx(32'h8000_0000, 32'h0000_0000, "R7 max -0,+0");
    mx(32'h0000_0000, 32'h8000_0000, "R7 max +0,-0");
    mn(32'h4120_0000, 32'hBF80_0000, "R7 min mixed");
    // R8 same sign and ties
    mn(32'hC000_0000, 32'hBF80_0000, "R8 min neg");
    mx(32'hC000_0000, 32'hBF80_0000, "R8 max neg");
    mn(32'h4000_0000, 32'h3F80_0000, "R8 min pos");
    mx(32'h3F80_0000, 32'h3F80_0000, "R8 tie");
    mn(32'h0000_0000, 32'h0000_0000, "R8 tie zero");
    // R9 infinities and subnormals
    mn(32'h0000_0001, 32'h007F_FFFF, "R9 sub pos");
    mx(32'h8000_0001, 32'h807F_FFFF, "R9 sub neg");
    mx(32'h007F_FFFF, 32'h0080_0000, "R9 sub vs norm");
    mn(32'hFF80_0000, 32'hFF7F_FFFF, "R9 -inf vs -max");
    mx(32'h7F80_0000, 32'h7F7F_FFFF, "R9 +inf vs max");
    mn(32'h8000_0001, 32'h0000_0000, "R9 -sub vs +0");
    // random normal pairs (R8 R7)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = rnd_norm();
      b = (i % 5 == 0) ? {a[31], rnd_norm()[30:0]} : rnd_norm();
      if (i % 2 == 0) mn(a, b, "R8 random min");
      else            mx(a, b, "R8 random max");
    end
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule